// File: doc/BRIEF.md
# Dual-Rail Precharge Datapath

A small bitwise logic function built in wave-style dual-rail precharge form. Each internal bit travels on a rail pair (true rail, false rail). A phase flag, toggled by every clock edge, splits time into precharge cycles, where every rail pair is forced to (0,0), and evaluate cycles, where each pair carries complementary values. No internal gate inverts: gates are pairs of positive monotonic functions, and a logical inversion is a swap of the two rails. A glitch-free wave of rising rails therefore moves through the logic in each evaluate cycle and falls back to zero in each precharge cycle.

The block keeps single-rail ports. Operands are sampled at the edge that closes a precharge cycle and are spread onto rail pairs for the evaluate cycle that follows. A two-stage dual-rail register holds the result through the next precharge, re-presents it in the next evaluate cycle, and a decoder turns it back into a single-rail output. The function computed per bit k is y[k] = ((a[k] AND b[k]) OR (b[k] XOR c[k])) XOR NOR(a[k], c[k]).

Top module: `drp_datapath`

## Requirements
- R1: During an evaluate cycle a rail pair encoding value v has its true rail equal to v and its false rail equal to NOT v.
- R2: No rail pair is ever (1,1).
- R3: The phase output phase_o toggles on every clock edge, reads 0 (precharge) in the first cycle after reset, and while it is 0 every internal rail wire is 0.
- R4: While phase_o is 1 (evaluate) exactly one wire of every rail pair is 1.
- R5: A rail wire rises only at the edge that starts an evaluate cycle and falls only at the edge that starts a precharge cycle.
- R6: The first stage of the dual-rail register keeps its content across every precharge cycle and always holds a complementary pair.
- R7: a_i, b_i and c_i are sampled at each edge where phase_o was 0 just before it; the matching y_o appears at the third edge after that sample and y_o changes at no other edge.
- R8: Per bit, y_o = ((a AND b) OR (b XOR c)) XOR NOT(a OR c), using the operands of one sample.
- R9: While rst_ni is low, y_o is 0 and phase_o is 0.
- R10: Input values present at an edge where phase_o was 1 have no effect on y_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; each edge flips the phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | Operand a, single-rail |
| b_i | input | 4 | Operand b, single-rail |
| c_i | input | 4 | Operand c, single-rail |
| y_o | output | 4 | Result, single-rail |
| phase_o | output | 1 | 1 in evaluate cycles, 0 in precharge cycles |

## Verification
A wrong rail in the logic or in the register's first stage shows at y_o at the third edge after the affected sample, as a wrong bit against the reference result, so every fault in the value path surfaces within two precharge/evaluate pairs. A phase flop that stops toggling shows at phase_o in the very next cycle and also freezes y_o. Inputs taken at the wrong edge appear as results that follow the junk values driven during evaluate cycles, which the bench puts there on purpose. Spacer and complementarity violations that would not change the decoded value are caught inside the design by the rail assertions.

// File: rtl/drp_pkg.sv
package drp_pkg;
  typedef enum logic [2:0] {
    GATE_AND,
    GATE_OR,
    GATE_XOR,
    GATE_NOR,
    GATE_XNOR
  } gate_op_e;
endpackage

// File: rtl/drp_gate.sv
module drp_gate #(
  parameter int               W  = 4,
  parameter drp_pkg::gate_op_e OP = drp_pkg::GATE_AND
) (
  input  logic [W-1:0] at_i,
  input  logic [W-1:0] af_i,
  input  logic [W-1:0] bt_i,
  input  logic [W-1:0] bf_i,
  output logic [W-1:0] yt_o,
  output logic [W-1:0] yf_o
);
  // both rails are positive monotonic; inversion is a rail swap
  generate
    if (OP == drp_pkg::GATE_AND) begin : g_and
      assign yt_o = at_i & bt_i;
      assign yf_o = af_i | bf_i;
    end else if (OP == drp_pkg::GATE_OR) begin : g_or
      assign yt_o = at_i | bt_i;
      assign yf_o = af_i & bf_i;
    end else if (OP == drp_pkg::GATE_NOR) begin : g_nor
      assign yt_o = af_i & bf_i;
      assign yf_o = at_i | bt_i;
    end else if (OP == drp_pkg::GATE_XOR) begin : g_xor
      assign yt_o = (at_i & bf_i) | (af_i & bt_i);
      assign yf_o = (at_i & bt_i) | (af_i & bf_i);
    end else begin : g_xnor
      assign yt_o = (at_i & bt_i) | (af_i & bf_i);
      assign yf_o = (at_i & bf_i) | (af_i & bt_i);
    end
  endgenerate
endmodule

// File: rtl/drp_enc.sv
module drp_enc #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         eval_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] f_o
);
  logic [W-1:0] d_q;

  // sample at the edge that ends precharge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      d_q <= '0;
    else if (!eval_i) d_q <= d_i;
  end

  assign t_o = {W{eval_i}} &  d_q;
  assign f_o = {W{eval_i}} & ~d_q;

  AST_ENC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> $stable(d_q)); // R10
endmodule

// File: rtl/drp_reg.sv
module drp_reg #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         eval_i,
  input  logic [W-1:0] dt_i,
  input  logic [W-1:0] df_i,
  output logic [W-1:0] qt_o,
  output logic [W-1:0] qf_o
);
  logic [W-1:0] s1_t_q, s1_f_q;

  // stage 1 captures the evaluated wave, holds it across precharge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_t_q <= RST_VAL;
      s1_f_q <= ~RST_VAL;
    end else if (eval_i) begin
      s1_t_q <= dt_i;
      s1_f_q <= df_i;
    end
  end

  // stage 2 is precharged with the logic
  assign qt_o = {W{eval_i}} & s1_t_q;
  assign qf_o = {W{eval_i}} & s1_f_q;

  AST_STAGE1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> ($stable(s1_t_q) && $stable(s1_f_q))); // R6
  AST_STAGE1_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_t_q ^ s1_f_q) == {W{1'b1}}); // R6
endmodule

// File: rtl/drp_dec.sv
module drp_dec #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         eval_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q <= '0;
    else if (eval_i) y_q <= t_i;
  end

  assign y_o = y_q;

  AST_DEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(y_q)); // R7
  AST_DEC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> ((t_i ^ f_i) == {W{1'b1}})); // R1
endmodule

// File: rtl/drp_datapath.sv
module drp_datapath #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o,
  output logic         phase_o
);
  import drp_pkg::*;

  localparam int NNETS = 9;
  localparam int RW    = NNETS * W;

  logic eval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eval_q <= 1'b0;
    else         eval_q <= ~eval_q;
  end

  logic [W-1:0] a_t, a_f, b_t, b_f, c_t, c_f;
  logic [W-1:0] ab_t, ab_f, bc_t, bc_f, or_t, or_f;
  logic [W-1:0] nr_t, nr_f, res_t, res_f, q_t, q_f;

  drp_enc #(.W(W)) u_enc_a (.clk_i, .rst_ni, .eval_i(eval_q), .d_i(a_i), .t_o(a_t), .f_o(a_f));
  drp_enc #(.W(W)) u_enc_b (.clk_i, .rst_ni, .eval_i(eval_q), .d_i(b_i), .t_o(b_t), .f_o(b_f));
  drp_enc #(.W(W)) u_enc_c (.clk_i, .rst_ni, .eval_i(eval_q), .d_i(c_i), .t_o(c_t), .f_o(c_f));

  drp_gate #(.W(W), .OP(GATE_AND)) u_and (
    .at_i(a_t), .af_i(a_f), .bt_i(b_t), .bf_i(b_f), .yt_o(ab_t), .yf_o(ab_f));
  drp_gate #(.W(W), .OP(GATE_XOR)) u_xor_bc (
    .at_i(b_t), .af_i(b_f), .bt_i(c_t), .bf_i(c_f), .yt_o(bc_t), .yf_o(bc_f));
  drp_gate #(.W(W), .OP(GATE_OR)) u_or (
    .at_i(ab_t), .af_i(ab_f), .bt_i(bc_t), .bf_i(bc_f), .yt_o(or_t), .yf_o(or_f));
  drp_gate #(.W(W), .OP(GATE_NOR)) u_nor (
    .at_i(a_t), .af_i(a_f), .bt_i(c_t), .bf_i(c_f), .yt_o(nr_t), .yf_o(nr_f));
  drp_gate #(.W(W), .OP(GATE_XOR)) u_xor_out (
    .at_i(or_t), .af_i(or_f), .bt_i(nr_t), .bf_i(nr_f), .yt_o(res_t), .yf_o(res_f));

  drp_reg #(.W(W), .RST_VAL('0)) u_reg (
    .clk_i, .rst_ni, .eval_i(eval_q), .dt_i(res_t), .df_i(res_f), .qt_o(q_t), .qf_o(q_f));

  drp_dec #(.W(W)) u_dec (
    .clk_i, .rst_ni, .eval_i(eval_q), .t_i(q_t), .f_i(q_f), .y_o(y_o));

  assign phase_o = eval_q;

  // all rail pairs gathered for the spacer and wave checks
  logic [RW-1:0] all_t, all_f;
  assign all_t = {a_t, b_t, c_t, ab_t, bc_t, or_t, nr_t, res_t, q_t};
  assign all_f = {a_f, b_f, c_f, ab_f, bc_f, or_f, nr_f, res_f, q_f};

  AST_NO_BOTH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_t & all_f) == '0); // R2
  AST_PRECHARGE_SPACER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_q |-> ((all_t | all_f) == '0)); // R3
  AST_EVAL_ONE_HOT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_q |-> ((all_t ^ all_f) == {RW{1'b1}})); // R4
  AST_RAIL_RISE_ON_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(all_t & ~$past(all_t))) || (|(all_f & ~$past(all_f)))) |-> $rose(eval_q)); // R5
  AST_RAIL_FALL_ON_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(~all_t & $past(all_t))) || (|(~all_f & $past(all_f)))) |-> $fell(eval_q)); // R5
  AST_PHASE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_q |=> !eval_q); // R3
endmodule

// File: tb/sim_drp_datapath.sv
module sim_drp_datapath;
  localparam int W      = 4;
  localparam int CLK_NS = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic [W-1:0] y_o;
  logic         phase_o;

  drp_datapath #(.W(W)) u0 (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string tag   = "R8";

  // reference model: sample on precharge edges, result due three edges later
  int           ph    = 0;
  int           edges = 0;
  logic [W-1:0] exp_y = '0;
  int           due_q[$];
  logic [W-1:0] val_q[$];

  function automatic logic [W-1:0] ref_f(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return ((a & b) | (b ^ c)) ^ ~(a | c);
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      edges++;
      if (due_q.size() > 0 && due_q[0] == edges) begin
        exp_y = val_q[0];
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
      if (ph == 0) begin
        due_q.push_back(edges + 3);
        val_q.push_back(ref_f(a_i, b_i, c_i));
      end
      ph = 1 - ph;
    end
  end

  // R1 R4 R6 feed the value path: any break shows in this comparison
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if (y_o !== exp_y) begin
        bad++;
        $display("FAIL %s y_o act=%h exp=%h t=%0t", tag, y_o, exp_y, $time);
      end
      total++;
      if (phase_o !== ph[0]) begin
        bad++;
        $display("FAIL R3 phase_o act=%b exp=%b t=%0t", phase_o, ph[0], $time);
      end
    end
  end

  // drive one operand set; junk during evaluate cycles (R10)
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                       input bit junk);
    while (phase_o !== 1'b0) @(negedge clk_i);
    a_i = a; b_i = b; c_i = c;
    @(negedge clk_i);
    if (junk) begin
      a_i = ~a ^ 4'h5; b_i = b ^ 4'hA; c_i = ~c;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #(CLK_NS * 3 + 2);
    total++;
    if (y_o !== '0 || phase_o !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset act=%h/%b exp=0/0", y_o, phase_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    tag = "R8";
    apply(4'h0, 4'h0, 4'h0, 0);
    apply(4'hF, 4'hF, 4'hF, 0);
    apply(4'h5, 4'hA, 4'h3, 0);

    tag = "R7";
    for (int i = 0; i < 4; i++) apply(4'(1 << i), 4'(8 >> i), 4'hF, 0);

    tag = "R8";
    for (int v = 0; v < 4096; v++) apply(v[3:0], v[7:4], v[11:8], 0);

    tag = "R10";
    for (int v = 0; v < 512; v++) apply(v[3:0] ^ 4'h9, v[8:5], v[7:4] ^ 4'h6, 1);

    // mid-run reset returns to R9 state
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    total++;
    if (y_o !== '0 || phase_o !== 1'b0) begin
      bad++;
      $display("FAIL R9 mid reset act=%h/%b exp=0/0", y_o, phase_o);
    end
    ph = 0; exp_y = '0; due_q.delete(); val_q.delete();
    @(negedge clk_i);
    rst_ni = 1'b1;
    tag = "R7";
    apply(4'hC, 4'h3, 4'h6, 1);
    apply(4'h1, 4'hE, 4'h7, 0);
    repeat (6) @(negedge clk_i);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule